// File: doc/BRIEF.md
# Transmit Buffer Host-Write Address Generator

This block produces byte addresses for host writes that fill the transmit area of a packet buffer memory. The memory is organised in 256-byte pages, so every address is an 8-bit page number above an 8-bit byte offset. The transmit area starts at page 0x40. It ends on the page just below a receive-start page that the host programs.

The host loads a start address and a byte count. Each write strobe the block accepts drives the memory write enable and passes the data through in the same cycle. On the next edge the address advances by one and the remaining count drops by one. When the count reaches zero, done rises and further strobes are ignored. The host then loads a new start address and count.

A ring control selects how the address moves past the top of the transmit area. With ring mode on, the address steps from the last byte of the last transmit page back to the first byte of page 0x40, so a packet can wrap without the host reloading the address. With ring mode off, which is the reset state, the address runs straight on into the receive area. This lets the whole memory be written for testing. In this mode the address wraps from 0xFFFF to 0x0000.

Top module: `txbuf_wr_addr_gen`

## Requirements
- R1: After reset, done_o is 1, mem_we_o is 0, mem_addr_o is 0x4000, ring mode is off and the receive-start page is 0x4C.
- R2: A load pulse sets mem_addr_o to start_addr_i and the remaining count to byte_cnt_i from the next cycle on. A load with count 0 leaves done_o at 1 and no write is accepted.
- R3: While done_o is 0, a write strobe asserts mem_we_o in the same cycle with mem_data_o equal to wr_data_i. The address then moves up by one, and offset 0xFF carries into the next page at offset 0x00.
- R4: With ring mode on, an accepted write at offset 0xFF of the page one below the receive-start page is followed by address 0x4000.
- R5: done_o rises in the cycle after exactly byte_cnt_i accepted writes, and not earlier.
- R6: While done_o is 1, a write strobe leaves mem_we_o at 0 and the address unchanged.
- R7: With ring mode off, the address crosses from the page below the receive-start page into the receive-start page.
- R8: With ring mode off, an accepted write at 0xFFFF is followed by address 0x0000.
- R9: rx_start_wr_i latches rx_start_page_i, and ring_wr_i latches ring_en_i. Clearing ring mode brings back the linear stepping.
- R10: When a load and a write strobe arrive in the same cycle, the loaded address and count take effect, and that strobe neither advances the address nor reduces the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load start address and byte count |
| start_addr_i | input | 16 | Start byte address (page, offset) |
| byte_cnt_i | input | 16 | Number of bytes to write |
| rx_start_wr_i | input | 1 | Write strobe for receive-start page |
| rx_start_page_i | input | 8 | Receive-start page value |
| ring_wr_i | input | 1 | Write strobe for ring enable |
| ring_en_i | input | 1 | Ring enable value |
| wr_strobe_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Host write data |
| mem_addr_o | output | 16 | Buffer memory byte address |
| mem_we_o | output | 1 | Buffer memory write enable |
| mem_data_o | output | 8 | Buffer memory write data |
| done_o | output | 1 | Byte count exhausted |

## Verification
Short write bursts are loaded just below page boundaries. Each burst is run four ways: ring off, ring on, ring on and then cleared, and starting at 0xFFFF. This separates the plain offset carry, the wrap at the programmed page, the linear crossing into the receive area and the wrap at the top of memory. A zero-length load and strobes sent after done show that exhausted transfers write nothing. A load that coincides with a strobe shows that the load has priority.

// File: rtl/txw_pkg.sv
package txw_pkg;
  localparam int PAGE_W = 8;
  localparam int OFF_W  = 8;
  localparam int ADDR_W = PAGE_W + OFF_W;

  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [OFF_W-1:0]  off;
  } buf_addr_t;
endpackage

// File: rtl/txw_cfg_regs.sv
module txw_cfg_regs
  import txw_pkg::*;
#(
  parameter logic [PAGE_W-1:0] RX_START_RST = 8'h4C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_start_wr_i,
  input  logic [PAGE_W-1:0] rx_start_page_i,
  input  logic              ring_wr_i,
  input  logic              ring_en_i,
  output logic [PAGE_W-1:0] rx_start_o,
  output logic              ring_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_start_o <= RX_START_RST;
      ring_en_o  <= 1'b0;
    end else begin
      if (rx_start_wr_i) rx_start_o <= rx_start_page_i;
      if (ring_wr_i)     ring_en_o  <= ring_en_i;
    end
  end

  a_r9_ring_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_wr_i |=> ring_en_o == $past(ring_en_i));
endmodule

// File: rtl/txw_addr_step.sv
module txw_addr_step
  import txw_pkg::*;
#(
  parameter logic [PAGE_W-1:0] TX_FIRST_PAGE = 8'h40
) (
  input  buf_addr_t         cur_i,
  input  logic              ring_en_i,
  input  logic [PAGE_W-1:0] rx_start_i,
  output buf_addr_t         nxt_o
);
  logic [PAGE_W-1:0] page_inc;
  logic              carry;

  always_comb begin
    carry        = &cur_i.off;
    page_inc     = cur_i.page + PAGE_W'(1);
    nxt_o.off    = cur_i.off + OFF_W'(1);
    nxt_o.page   = cur_i.page;
    if (carry) begin
      // ring: entering the receive-start page folds back to the tx area
      if (ring_en_i && page_inc == rx_start_i) nxt_o.page = TX_FIRST_PAGE;
      else                                     nxt_o.page = page_inc;
    end
  end
endmodule

// File: rtl/txw_byte_counter.sv
module txw_byte_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dec_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (load_i) cnt_q <= cnt_i;
    else if (dec_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = (cnt_q == '0);

  a_r5_count_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> cnt_q != '0);
endmodule

// File: rtl/txbuf_wr_addr_gen.sv
module txbuf_wr_addr_gen
  import txw_pkg::*;
#(
  parameter int                CNT_W         = 16,
  parameter int                DATA_W        = 8,
  parameter logic [PAGE_W-1:0] TX_FIRST_PAGE = 8'h40,
  parameter logic [PAGE_W-1:0] RX_START_RST  = 8'h4C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic              rx_start_wr_i,
  input  logic [PAGE_W-1:0] rx_start_page_i,
  input  logic              ring_wr_i,
  input  logic              ring_en_i,
  input  logic              wr_strobe_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              done_o
);
  localparam buf_addr_t RST_ADDR = '{page: TX_FIRST_PAGE, off: '0};

  buf_addr_t         addr_q, addr_nxt;
  logic [PAGE_W-1:0] rx_start;
  logic              ring_en;
  logic              accept;

  txw_cfg_regs #(.RX_START_RST(RX_START_RST)) i_cfg (
    .clk_i, .rst_ni, .rx_start_wr_i, .rx_start_page_i,
    .ring_wr_i, .ring_en_i,
    .rx_start_o (rx_start),
    .ring_en_o  (ring_en)
  );

  txw_addr_step #(.TX_FIRST_PAGE(TX_FIRST_PAGE)) i_step (
    .cur_i      (addr_q),
    .ring_en_i  (ring_en),
    .rx_start_i (rx_start),
    .nxt_o      (addr_nxt)
  );

  txw_byte_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni,
    .load_i (load_i),
    .cnt_i  (byte_cnt_i),
    .dec_i  (accept && !load_i),
    .done_o (done_o)
  );

  assign accept = wr_strobe_i && !done_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= RST_ADDR;
    else if (load_i) addr_q <= buf_addr_t'(start_addr_i);
    else if (accept) addr_q <= addr_nxt;
  end

  assign mem_addr_o = addr_q;
  assign mem_we_o   = accept;
  assign mem_data_o = wr_data_i;

  a_r6_no_we_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_we_o);
  a_r6_hold_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> $stable(mem_addr_o));
  a_r3_step_in_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !load_i && addr_q.off != '1) |=> mem_addr_o == $past(mem_addr_o) + ADDR_W'(1));
  a_r4_ring_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !load_i && ring_en && addr_q.off == '1 && addr_q.page == rx_start - PAGE_W'(1))
    |=> mem_addr_o == ADDR_W'(RST_ADDR));
  a_r8_top_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !load_i && !ring_en && mem_addr_o == '1) |=> mem_addr_o == '0);
  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> mem_addr_o == $past(start_addr_i));
endmodule

// File: tb/test_txbuf_wr_addr_gen.sv
module test_txbuf_wr_addr_gen;
  logic        clk_i = 0, rst_ni = 0;
  logic        load_i = 0, rx_start_wr_i = 0, ring_wr_i = 0, ring_en_i = 0, wr_strobe_i = 0;
  logic [15:0] start_addr_i = 0, byte_cnt_i = 0;
  logic [7:0]  rx_start_page_i = 0, wr_data_i = 0;
  logic [15:0] mem_addr_o;
  logic        mem_we_o, done_o;
  logic [7:0]  mem_data_o;
  int          n_chk = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  txbuf_wr_addr_gen i_txbuf_wr_addr_gen (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] n);
    @(negedge clk_i); load_i = 1; start_addr_i = a; byte_cnt_i = n;
    @(negedge clk_i); load_i = 0;
  endtask

  // one strobe; checks address/we/data seen by memory in that cycle
  task automatic wr(input string req, input logic [15:0] exp_addr, input logic exp_we);
    @(negedge clk_i); wr_strobe_i = 1; wr_data_i = exp_addr[7:0] ^ 8'h5A; #1;
    chk(req, mem_addr_o, exp_addr);
    chk(req, mem_we_o, exp_we);
    if (exp_we) chk("R3 data", mem_data_o, exp_addr[7:0] ^ 8'h5A);
    @(negedge clk_i); wr_strobe_i = 0;
  endtask

  task automatic set_rx(input logic [7:0] p);
    @(negedge clk_i); rx_start_wr_i = 1; rx_start_page_i = p;
    @(negedge clk_i); rx_start_wr_i = 0;
  endtask

  task automatic set_ring(input logic e);
    @(negedge clk_i); ring_wr_i = 1; ring_en_i = e;
    @(negedge clk_i); ring_wr_i = 0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 done", done_o, 1); chk("R1 we", mem_we_o, 0); chk("R1 addr", mem_addr_o, 16'h4000);
  endtask

  task automatic t_reset_ring_default;
    // default rx start 0x4C, ring off: crosses into 0x4C
    load(16'h4BFF, 2);
    wr("R1 default", 16'h4BFF, 1); wr("R1 default rx page", 16'h4C00, 1);
  endtask

  task automatic t_linear_step;
    load(16'h40FE, 4);
    chk("R2 load done low", done_o, 0);
    wr("R3", 16'h40FE, 1); wr("R3", 16'h40FF, 1); wr("R3 carry", 16'h4100, 1);
    chk("R5 not early", done_o, 0);
    wr("R3", 16'h4101, 1);
    chk("R5 done", done_o, 1);
  endtask

  task automatic t_ignore_after_done;
    wr("R6 ignored", 16'h4102, 0);
    wr("R6 addr held", 16'h4102, 0);
  endtask

  task automatic t_linear_past_rx;
    set_rx(8'h46);
    load(16'h45FF, 2);
    wr("R7", 16'h45FF, 1); wr("R7 into rx", 16'h4600, 1);
  endtask

  task automatic t_ring;
    set_ring(1);
    load(16'h45FE, 3);
    wr("R4", 16'h45FE, 1); wr("R4", 16'h45FF, 1); wr("R4 wrap", 16'h4000, 1);
    chk("R5 ring done", done_o, 1);
  endtask

  task automatic t_ring_off;
    set_ring(0);
    load(16'h45FF, 2);
    wr("R9 ring cleared", 16'h45FF, 1); wr("R9 linear again", 16'h4600, 1);
  endtask

  task automatic t_top_wrap;
    load(16'hFFFF, 2);
    wr("R8", 16'hFFFF, 1); wr("R8 wrap", 16'h0000, 1);
  endtask

  task automatic t_zero_count;
    load(16'h5000, 0);
    chk("R2 zero done", done_o, 1);
    wr("R2 zero no write", 16'h5000, 0);
  endtask

  task automatic t_load_and_write;
    load(16'h5010, 1);
    @(negedge clk_i); load_i = 1; start_addr_i = 16'h6000; byte_cnt_i = 2; wr_strobe_i = 1;
    @(negedge clk_i); load_i = 0; wr_strobe_i = 0; #1;
    chk("R10 addr", mem_addr_o, 16'h6000);
    chk("R10 done", done_o, 0);
    wr("R10 first", 16'h6000, 1);
    chk("R10 count kept", done_o, 0);
    wr("R10 second", 16'h6001, 1);
    chk("R10 end", done_o, 1);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #35 rst_ni = 1;
    t_reset();
    t_reset_ring_default();
    t_linear_step();
    t_ignore_after_done();
    t_linear_past_rx();
    t_ring();
    t_ring_off();
    t_top_wrap();
    t_zero_count();
    t_load_and_write();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule